// File: doc/BRIEF.md
# Three-Bit-Coded 32-Bit Arithmetic-Logic Unit

This block is the arithmetic-logic unit of a small single-cycle processor datapath. It is purely combinational: it takes two operands and a three-bit operation code, and in the same cycle it returns a result word and a flag that marks an all-zero result. There is no clock, no reset and no stored state. The surrounding control logic decodes each instruction into one of six operations: bitwise AND, OR and XOR, wrapping add, wrapping subtract, and signed set-less-than.

Two ports are reserved for later versions. A five-bit shift-amount input exists so that the integrating design can wire it now, and it drives it with zero. An overflow output exists as well, but it is held low. Codes 110 and 111 are not yet assigned, and they return a zero result.

Top module: `alu3_core`

## Requirements
- R1: The logic operations work bit by bit. Code 3'b000 gives A AND B, code 3'b010 gives A OR B and code 3'b101 gives A XOR B.
- R2: Code 3'b001 gives A + B modulo 2^32. A carry out of bit 31 is dropped.
- R3: Code 3'b011 gives A - B modulo 2^32. A borrow is dropped.
- R4: Code 3'b100 compares A and B as signed two's-complement values. It returns 32'd1 when A < B and 32'd0 otherwise, and this holds across the sign boundary.
- R5: The unassigned codes 3'b110 and 3'b111 give a result of 32'd0.
- R6: The zero flag is 1 exactly when all 32 result bits are 0, for every code.
- R7: The shift-amount input has no effect on the result or the flags.
- R8: The overflow output is always 0, including when a signed add or subtract overflows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| opnd_a | input | 32 | First operand |
| opnd_b | input | 32 | Second operand |
| op_sel | input | 3 | Operation code |
| shift_amt | input | 5 | Reserved shift amount, has no effect |
| result | output | 32 | Operation result |
| zero_flag | output | 1 | High when result is all zeros |
| overflow | output | 1 | Reserved, held at 0 |

## Verification
The block holds no state, so any internal fault shows up at the ports in the same cycle as the stimulus that exposes it. A wrong carry-in or a wrong operand inversion in the shared adder corrupts ADD, SUB and set-less-than together. A wrong sign term shows only for operands of opposite sign. A wrong reduction tree shows as a zero flag that disagrees with the result word. The bench therefore uses sign-boundary and carry-chain operands next to pseudo-random ones, and it compares every code against a behavioural model on each clock.

// File: rtl/alu3_pkg.sv
package alu3_pkg;
  localparam int unsigned OP_W = 3;

  typedef enum logic [OP_W-1:0] {
    OP_AND = 3'b000,
    OP_ADD = 3'b001,
    OP_OR  = 3'b010,
    OP_SUB = 3'b011,
    OP_SLT = 3'b100,
    OP_XOR = 3'b101,
    OP_RS6 = 3'b110,
    OP_RS7 = 3'b111
  } alu_op_e;
endpackage

// File: rtl/alu3_addsub.sv
// Shared adder for ADD, SUB and signed less-than.
module alu3_addsub #(
  parameter int unsigned WIDTH = 32
) (
  input  logic [WIDTH-1:0] a_i,
  input  logic [WIDTH-1:0] b_i,
  input  logic             sub_i,
  output logic [WIDTH-1:0] sum_o,
  output logic             lt_o
);
  localparam int unsigned MSB = WIDTH - 1;

  logic [WIDTH-1:0] b_eff;

  always_comb begin
    b_eff = sub_i ? ~b_i : b_i;
    sum_o = a_i + b_eff + {{(WIDTH-1){1'b0}}, sub_i};
    // Opposite signs: the negative operand is smaller. Same signs: no
    // overflow is possible, so the sign of the difference decides.
    if (a_i[MSB] != b_i[MSB]) lt_o = a_i[MSB];
    else                      lt_o = sum_o[MSB];
  end
endmodule

// File: rtl/alu3_logic.sv
module alu3_logic #(
  parameter int unsigned WIDTH = 32
) (
  input  logic [WIDTH-1:0] a_i,
  input  logic [WIDTH-1:0] b_i,
  output logic [WIDTH-1:0] and_o,
  output logic [WIDTH-1:0] or_o,
  output logic [WIDTH-1:0] xor_o
);
  always_comb begin
    and_o = a_i & b_i;
    or_o  = a_i | b_i;
    xor_o = a_i ^ b_i;
  end
endmodule

// File: rtl/alu3_zdet.sv
// Two-level zero detect: OR each chunk, then NOR the chunk results.
module alu3_zdet #(
  parameter int unsigned WIDTH = 32,
  parameter int unsigned CHUNK = 8
) (
  input  logic [WIDTH-1:0] val_i,
  output logic             zero_o
);
  localparam int unsigned NCHUNK = (WIDTH + CHUNK - 1) / CHUNK;
  localparam int unsigned PADW   = NCHUNK * CHUNK;

  logic [PADW-1:0]   padded;
  logic [NCHUNK-1:0] chunk_any;

  always_comb begin
    padded = '0;
    padded[WIDTH-1:0] = val_i;
  end

  for (genvar g = 0; g < NCHUNK; g++) begin : g_chunk
    assign chunk_any[g] = |padded[g*CHUNK +: CHUNK];
  end

  assign zero_o = ~|chunk_any;
endmodule

// File: rtl/alu3_core.sv
module alu3_core
  import alu3_pkg::*;
#(
  parameter int unsigned WIDTH   = 32,
  parameter int unsigned SHAMT_W = 5,
  parameter int unsigned ZCHUNK  = 8
) (
  input  logic [WIDTH-1:0]   opnd_a,
  input  logic [WIDTH-1:0]   opnd_b,
  input  logic [OP_W-1:0]    op_sel,
  input  logic [SHAMT_W-1:0] shift_amt,
  output logic [WIDTH-1:0]   result,
  output logic               zero_flag,
  output logic               overflow
);
  alu_op_e          op;
  logic             do_sub;
  logic [WIDTH-1:0] sum_w, and_w, or_w, xor_w;
  logic             lt_w;
  logic             shamt_unused;

  assign op           = alu_op_e'(op_sel);
  assign do_sub       = (op == OP_SUB) || (op == OP_SLT);
  assign shamt_unused = ^shift_amt;
  assign overflow     = 1'b0;

  alu3_addsub #(.WIDTH(WIDTH)) u_addsub (
    .a_i(opnd_a), .b_i(opnd_b), .sub_i(do_sub), .sum_o(sum_w), .lt_o(lt_w)
  );

  alu3_logic #(.WIDTH(WIDTH)) u_logic (
    .a_i(opnd_a), .b_i(opnd_b), .and_o(and_w), .or_o(or_w), .xor_o(xor_w)
  );

  always_comb begin
    unique case (op)
      OP_AND:  result = and_w;
      OP_OR:   result = or_w;
      OP_XOR:  result = xor_w;
      OP_ADD,
      OP_SUB:  result = sum_w;
      OP_SLT:  result = {{(WIDTH-1){1'b0}}, lt_w};
      default: result = '0;
    endcase
  end

  alu3_zdet #(.WIDTH(WIDTH), .CHUNK(ZCHUNK)) u_zdet (
    .val_i(result), .zero_o(zero_flag)
  );
endmodule

// File: rtl/alu3_checks.sv
module alu3_checks #(
  parameter int unsigned WIDTH   = 32,
  parameter int unsigned SHAMT_W = 5
) (
  input logic [WIDTH-1:0]   opnd_a,
  input logic [WIDTH-1:0]   opnd_b,
  input logic [2:0]         op_sel,
  input logic [SHAMT_W-1:0] shift_amt,
  input logic [WIDTH-1:0]   result,
  input logic               zero_flag,
  input logic               overflow
);
  logic known;
  logic shamt_unused;
  assign shamt_unused = ^shift_amt;
  assign known = !$isunknown({opnd_a, opnd_b, op_sel});

  always_comb begin
    if (known) begin
      assert_zero_flag_R6: assert (zero_flag == (result == '0))
        else $error("zero flag disagrees with result");
      assert_no_overflow_R8: assert (overflow == 1'b0)
        else $error("overflow raised");
      if (op_sel == 3'b110 || op_sel == 3'b111) begin
        assert_unused_code_R5: assert (result == '0)
          else $error("unassigned code gave nonzero result");
      end
      if (op_sel == 3'b100) begin
        assert_slt_bool_R4: assert (result[WIDTH-1:1] == '0)
          else $error("set-less-than result not 0 or 1");
      end
      if (op_sel == 3'b001) begin
        assert_add_inverse_R2: assert (result - opnd_a == opnd_b)
          else $error("add result inconsistent");
      end
      if (op_sel == 3'b011) begin
        assert_sub_inverse_R3: assert (result + opnd_b == opnd_a)
          else $error("sub result inconsistent");
      end
      if (op_sel == 3'b000) begin
        assert_and_subset_R1: assert ((result & ~opnd_a) == '0)
          else $error("and result has bits outside A");
      end
    end
  end
endmodule

bind alu3_core alu3_checks #(.WIDTH(WIDTH), .SHAMT_W(SHAMT_W)) u_chk (
  .opnd_a(opnd_a), .opnd_b(opnd_b), .op_sel(op_sel), .shift_amt(shift_amt),
  .result(result), .zero_flag(zero_flag), .overflow(overflow)
);

// File: tb/sim_alu3_core.sv
module sim_alu3_core;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] a, b;
  logic [2:0]  op;
  logic [4:0]  sh;
  logic [31:0] res;
  logic        zf, ovf;
  int          checks = 0;
  int          fails  = 0;
  logic [31:0] seed = 32'h1234_5678;

  always #4 clk = ~clk;

  alu3_core u0 (
    .opnd_a(a), .opnd_b(b), .op_sel(op), .shift_amt(sh),
    .result(res), .zero_flag(zf), .overflow(ovf)
  );

  function automatic logic [31:0] model(input logic [31:0] x, y, input logic [2:0] c);
    longint sx, sy;
    sx = longint'($signed(x));
    sy = longint'($signed(y));
    case (c)
      3'd0: return x & y;
      3'd1: return 32'((longint'(x) + longint'(y)) % 64'h1_0000_0000);
      3'd2: return x | y;
      3'd3: return 32'((longint'(x) - longint'(y) + 64'h1_0000_0000) % 64'h1_0000_0000);
      3'd4: return (sx < sy) ? 32'd1 : 32'd0;
      3'd5: return x ^ y;
      default: return 32'd0;
    endcase
  endfunction

  function automatic string tag_of(input logic [2:0] c);
    case (c)
      3'd1: return "R2";
      3'd3: return "R3";
      3'd4: return "R4";
      3'd6, 3'd7: return "R5";
      default: return "R1";
    endcase
  endfunction

  function automatic logic [31:0] next_rand(input logic [31:0] s);
    logic [31:0] t;
    t = s ^ (s << 13);
    t = t ^ (t >> 17);
    return t ^ (t << 5);
  endfunction

  task automatic chk(input string tag, input logic [31:0] got, exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s a=%h b=%h op=%0d got=%h exp=%h", tag, a, b, op, got, exp);
    end
  endtask

  task automatic run(input logic [31:0] x, y, input logic [2:0] c, input logic [4:0] s);
    logic [31:0] e;
    @(posedge clk);
    a = x; b = y; op = c; sh = s;
    @(negedge clk);
    e = model(x, y, c);
    chk(tag_of(c), res, e);
    chk("R6", {31'd0, zf}, {31'd0, (e == 32'd0)});
    chk("R8", {31'd0, ovf}, 32'd0);
  endtask

  logic [31:0] corners [10] = '{32'h0, 32'hFFFF_FFFF, 32'h7FFF_FFFF, 32'h8000_0000,
                                32'h1, 32'h5, 32'hFFFF_FFFE, 32'hFFFF_FFFD,
                                32'hAAAA_5555, 32'h0F0F_F0F0};

  initial begin
    a = '0; b = '0; op = '0; sh = '0;
    repeat (2) @(posedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // Reset-state check: all-zero inputs give AND of zeros
    chk("R1", res, 32'd0);
    chk("R6", {31'd0, zf}, 32'd1);
    // Corner pairs across every code (R1..R5 by code)
    for (int i = 0; i < 10; i++)
      for (int j = 0; j < 10; j++)
        for (int c = 0; c < 8; c++)
          run(corners[i], corners[j], 3'(c), 5'd0);
    // Targeted sign-boundary compares (R4)
    run(32'h8000_0000, 32'h7FFF_FFFF, 3'd4, 5'd0);
    run(32'h7FFF_FFFF, 32'h8000_0000, 3'd4, 5'd0);
    run(32'd5, 32'd5, 3'd4, 5'd0);
    // Signed overflow on add/sub must still leave overflow low (R8)
    run(32'h7FFF_FFFF, 32'h1, 3'd1, 5'd0);
    run(32'h8000_0000, 32'h1, 3'd3, 5'd0);
    // Pseudo-random operands with random shift amount
    for (int k = 0; k < 400; k++) begin
      logic [31:0] x, y;
      seed = next_rand(seed); x = seed;
      seed = next_rand(seed); y = (k % 5 == 0) ? x : seed;
      run(x, y, 3'(k % 8), 5'(seed[4:0]));
    end
    // Shift amount has no effect (R7)
    for (int c = 0; c < 8; c++) begin
      logic [31:0] r0;
      logic        z0;
      run(32'h1357_9BDF, 32'h0246_8ACE, 3'(c), 5'd0);
      r0 = res; z0 = zf;
      run(32'h1357_9BDF, 32'h0246_8ACE, 3'(c), 5'd31);
      chk("R7", res, r0);
      chk("R7", {31'd0, zf}, {31'd0, z0});
    end
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    checks++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule